// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device side of a serial NOR flash that serves read commands only. It watches the chip select, the serial clock and two I/O lines. All of them are brought into the system clock domain, and the block reacts to the edges of the serial clock it sees there. After an 8-bit command comes in on the first data line, the block takes a 24-bit start address. It waits out the dummy clocks that the command calls for, then streams bytes from an internal byte array until chip select goes high. The byte array is filled through a plain synchronous write port.

Three commands are served: a plain read with one bit per clock, a fast read with eight dummy clocks, and a dual read. In the dual read the address, the dummy phase and the data all move two bits per clock. A busy input stands for a program, erase or status-write cycle running elsewhere in the device. While it is high, the fast read and the dual read are refused.

Top module: `flash_read_resp`

## Requirements
- R1: While chip select is high, and after reset, both output enables are low (io_oe = 00).
- R2: Opcodes and single-line address bits are sampled on io_in[0] at rising serial clock edges, MSB first. Opcode 03h starts a plain read. Its data goes out MSB first on io_out[1] with io_oe = 10, and the first bit is valid before the first rising edge after the last address bit.
- R3: The start address is 24 bits, sent MSB first. Only its low log2(DEPTH) bits select the byte, so the upper bits are ignored.
- R4: After each byte the address advances by one. After byte DEPTH-1 it wraps to byte 0, and the stream goes on for as long as chip select stays low.
- R5: Opcode 0Bh takes a single-line address, then 8 dummy clocks. Its data is then sent as in R2.
- R6: Opcode BBh takes the address in 12 clocks of two bits each, with io_in[1] as the more significant bit of each pair. Then come 4 dummy clocks. Data follows two bits per clock on io_out[1] (the higher bit) and io_out[0], with io_oe = 11, so each byte takes 4 clocks.
- R7: Output data changes only after a falling serial clock edge. It holds steady across the rising edge where the host samples it.
- R8: Raising chip select during the data phase ends the read and drops the output enables. The next frame is decoded from a fresh opcode.
- R9: An opcode other than 03h, 0Bh or BBh leaves the outputs disabled for the rest of the frame, whatever the later clocks carry.
- R10: If busy is high when the last opcode bit is sampled, a 0Bh or BBh command is refused and the outputs stay disabled for the whole frame.
- R11: A 03h command is served normally while busy is high.
- R12: A write on the array port (mem_we high) stores mem_wdata at mem_waddr, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| io_in | input | 2 | Serial data lines from the host; bit 0 is the single-line input |
| io_out | output | 2 | Serial data lines to the host; bit 1 is the single-line output |
| io_oe | output | 2 | Per-line output enable |
| busy | input | 1 | A program, erase or status-write cycle is in progress |
| mem_we | input | 1 | Byte array write strobe |
| mem_waddr | input | AW | Byte array write address |
| mem_wdata | input | 8 | Byte array write data |

## Verification
Every serial-clock edge takes three system clocks to act. Two go to the pin synchronizer and one to the output register. The bench therefore holds each half of the serial clock for six system clocks and samples at the very end of each half. It reads the outputs at the end of the low half, as the host would just before it raises the clock, and again at the end of the high half to confirm they did not move. Chip-select effects are checked two half periods after chip select rises, well after the two-flop synchronizer and the enable register have settled.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_FAST = 8'h0B;
  localparam logic [7:0] OPC_DUAL = 8'hBB;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE
  } rd_state_e;

  typedef struct packed {
    logic       valid;
    logic       dual;
    logic       busy_rej;
    logic [3:0] dummy_clks;
  } cmd_info_t;

  function automatic cmd_info_t decode_opc(input logic [7:0] opc);
    cmd_info_t c;
    c = '0;
    case (opc)
      OPC_READ: c.valid = 1'b1;
      OPC_FAST: begin
        c.valid = 1'b1; c.busy_rej = 1'b1; c.dummy_clks = 4'd8;
      end
      OPC_DUAL: begin
        c.valid = 1'b1; c.dual = 1'b1; c.busy_rej = 1'b1; c.dummy_clks = 4'd4;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  // advance within a power-of-two array, wrapping at the top
  function automatic logic [23:0] next_addr(input logic [23:0] a, input int aw);
    logic [23:0] mask;
    mask = (24'd1 << aw) - 24'd1;
    return (a + 24'd1) & mask;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      d_sync <= RST_VAL;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/rd_byte_array.sv
module rd_byte_array #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] bytes_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) bytes_q[waddr] <= wdata;
  end

  assign rdata = bytes_q[raddr];
endmodule

// File: rtl/rd_sequencer.sv
module rd_sequencer
  import flash_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          sclk_s,
  input  logic [1:0]    io_s,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_idx,
  output logic [1:0]    io_out,
  output logic [1:0]    io_oe,
  output logic          cs_act,
  output logic          sclk_rise,
  output logic          sclk_fall,
  output logic          opc_done,
  output logic          cmd_reject,
  output logic          byte_done,
  output logic          dual_q,
  output rd_state_e     st_q,
  output logic [23:0]   addr_q
);
  logic       sclk_prev;
  logic [4:0] bit_cnt;
  logic [6:0] opc_sr;
  logic [3:0] dummy_len;
  logic [7:0] data_sr;
  logic [2:0] data_cnt;

  logic [7:0]  opc_next;
  cmd_info_t   info;
  logic [23:0] addr_next;
  logic [4:0]  addr_last;
  logic [2:0]  data_last;
  logic [7:0]  cur_byte;

  assign cs_act    = ~cs_n_s;
  assign sclk_rise = cs_act & sclk_s & ~sclk_prev;
  assign sclk_fall = cs_act & ~sclk_s & sclk_prev;

  assign opc_next   = {opc_sr, io_s[0]};
  assign info       = decode_opc(opc_next);
  assign opc_done   = sclk_rise && (st_q == ST_OPC) && (bit_cnt == 5'd7);
  assign cmd_reject = opc_done && info.valid && info.busy_rej && busy;

  assign addr_next = dual_q ? {addr_q[21:0], io_s[1], io_s[0]} : {addr_q[22:0], io_s[0]};
  assign addr_last = dual_q ? 5'd11 : 5'd23;
  assign data_last = dual_q ? 3'd3 : 3'd7;
  assign byte_done = sclk_fall && (st_q == ST_DATA) && (data_cnt == data_last);
  assign cur_byte  = (data_cnt == 3'd0) ? rd_data : data_sr;
  assign rd_idx    = addr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OPC;
      bit_cnt   <= '0;
      opc_sr    <= '0;
      dummy_len <= '0;
      dual_q    <= 1'b0;
      addr_q    <= '0;
      data_sr   <= '0;
      data_cnt  <= '0;
      io_out    <= '0;
      io_oe     <= '0;
    end else if (!cs_act) begin
      st_q     <= ST_OPC;
      bit_cnt  <= '0;
      data_cnt <= '0;
      io_oe    <= '0;
    end else if (sclk_rise) begin
      case (st_q)
        ST_OPC: begin
          opc_sr  <= opc_next[6:0];
          bit_cnt <= bit_cnt + 5'd1;
          if (opc_done) begin
            bit_cnt   <= '0;
            dual_q    <= info.dual;
            dummy_len <= info.dummy_clks;
            st_q      <= (!info.valid || cmd_reject) ? ST_IGNORE : ST_ADDR;
          end
        end
        ST_ADDR: begin
          addr_q  <= addr_next;
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt == addr_last) begin
            bit_cnt  <= '0;
            data_cnt <= '0;
            st_q     <= (dummy_len != 4'd0) ? ST_DUMMY : ST_DATA;
          end
        end
        ST_DUMMY: begin
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt == ({1'b0, dummy_len} - 5'd1)) begin
            bit_cnt <= '0;
            st_q    <= ST_DATA;
          end
        end
        default: ;
      endcase
    end else if (sclk_fall && st_q == ST_DATA) begin
      if (dual_q) begin
        io_out  <= cur_byte[7:6];
        data_sr <= {cur_byte[5:0], 2'b00};
        io_oe   <= 2'b11;
      end else begin
        io_out  <= {cur_byte[7], 1'b0};
        data_sr <= {cur_byte[6:0], 1'b0};
        io_oe   <= 2'b10;
      end
      if (byte_done) begin
        data_cnt <= '0;
        addr_q   <= next_addr(addr_q, AW);
      end else begin
        data_cnt <= data_cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/flash_read_resp.sv
module flash_read_resp
  import flash_rd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [1:0]    io_in,
  output logic [1:0]    io_out,
  output logic [1:0]    io_oe,
  input  logic          busy,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata
);
  logic [3:0]    pins_s;
  logic [AW-1:0] rd_idx;
  logic [7:0]    rd_data;
  logic          cs_act, sclk_rise, sclk_fall, opc_done, cmd_reject, byte_done, dual_q;
  rd_state_e     st_q;
  logic [23:0]   addr_q;

  spi_pin_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({cs_n, sclk, io_in}),
    .d_sync(pins_s)
  );

  rd_byte_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_idx), .rdata(rd_data)
  );

  rd_sequencer #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[3]), .sclk_s(pins_s[2]), .io_s(pins_s[1:0]),
    .busy(busy), .rd_data(rd_data), .rd_idx(rd_idx),
    .io_out(io_out), .io_oe(io_oe),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .opc_done(opc_done), .cmd_reject(cmd_reject), .byte_done(byte_done),
    .dual_q(dual_q), .st_q(st_q), .addr_q(addr_q)
  );
endmodule

// File: rtl/flash_read_resp_chk.sv
module flash_read_resp_chk
  import flash_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_act,
  input logic        sclk_fall,
  input logic        cmd_reject,
  input logic        byte_done,
  input logic        dual_q,
  input rd_state_e   st_q,
  input logic [23:0] addr_q,
  input logic [1:0]  io_out,
  input logic [1:0]  io_oe
);
  // R1
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> io_oe == 2'b00);

  // R7
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out != $past(io_out)) |-> $past(sclk_fall));

  // R9
  ignore_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE) |-> io_oe == 2'b00);

  // R10
  busy_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> (st_q == ST_IGNORE) || !cs_act);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (addr_q[AW-1:0] == {AW{1'b1}})) |=> addr_q == 24'd0);

  // R6
  dual_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 2'b11) |-> dual_q);

  // R2
  single_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 2'b10) |-> !dual_q);
endmodule

bind flash_read_resp flash_read_resp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .cmd_reject(cmd_reject), .byte_done(byte_done), .dual_q(dual_q),
  .st_q(st_q), .addr_q(addr_q), .io_out(io_out), .io_oe(io_oe)
);

// File: tb/sim_flash_read_resp.sv
module sim_flash_read_resp;
  localparam int DEPTH = 256;
  localparam int HP    = 6;

  logic       clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, busy = 1'b0;
  logic       mem_we = 1'b0;
  logic [1:0] io_in = 2'b00;
  logic [7:0] mem_waddr = '0, mem_wdata = '0;
  wire  [1:0] io_out, io_oe;
  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  flash_read_resp #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(((i * 29 + 7) % 256) ^ (i / 16));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  // one serial clock: drive, hold low, sample, rise, hold high, sample, fall
  task automatic tick(input logic [1:0] drv, output logic [1:0] s_out,
                      output logic [1:0] s_oe, output logic [1:0] s_hi);
    io_in = drv;
    half();
    s_out = io_out;
    s_oe  = io_oe;
    sclk  = 1'b1;
    half();
    s_hi  = io_out;
    sclk  = 1'b0;
  endtask

  task automatic start_f();
    cs_n = 1'b0;
    half();
  endtask

  task automatic end_f();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [1:0] o, e, h;
    for (int i = 7; i >= 0; i--) tick({1'b0, b[i]}, o, e, h);
  endtask

  task automatic send_addr(input logic [23:0] a, input bit dual);
    logic [1:0] o, e, h;
    if (dual) for (int i = 11; i >= 0; i--) tick({a[2*i+1], a[2*i]}, o, e, h);
    else      for (int i = 23; i >= 0; i--) tick({1'b0, a[i]}, o, e, h);
  endtask

  task automatic dummies(input int n);
    logic [1:0] o, e, h;
    for (int i = 0; i < n; i++) tick(2'b11, o, e, h);
  endtask

  task automatic read_bytes(input logic [23:0] a, input int n, input bit dual, input string req);
    logic [1:0] o, e, h;
    logic [7:0] got;
    int oe_bad = 0, moved = 0;
    logic [1:0] oe_exp;
    oe_exp = dual ? 2'b11 : 2'b10;
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = (int'(a % 24'(DEPTH)) + k) % DEPTH;
      got = '0;
      if (dual) begin
        for (int j = 0; j < 4; j++) begin
          tick(2'b00, o, e, h);
          got = {got[5:0], o};
          if (e != oe_exp) oe_bad++;
          if (h != o) moved++;
        end
      end else begin
        for (int j = 0; j < 8; j++) begin
          tick(2'b00, o, e, h);
          got = {got[6:0], o[1]};
          if (e != oe_exp) oe_bad++;
          if (h != o) moved++;
        end
      end
      chk(got == model[idx], req, got, model[idx]);
    end
    chk(oe_bad == 0, {req, " output enable"}, oe_bad, 0);
    // R7: data held across the sampling edge
    chk(moved == 0, "R7 stable across rise", moved, 0);
  endtask

  task automatic do_read(input logic [7:0] opc, input logic [23:0] a, input int n, input string req);
    start_f();
    send_byte(opc);
    send_addr(a, opc == 8'hBB);
    if (opc == 8'h0B) dummies(8);
    if (opc == 8'hBB) dummies(4);
    read_bytes(a, n, opc == 8'hBB, req);
    end_f();
  endtask

  // frame that must never enable the outputs
  task automatic quiet_frame(input logic [7:0] opc, input int n, input string req);
    logic [1:0] o, e, h;
    int on = 0;
    start_f();
    send_byte(opc);
    for (int i = 0; i < n; i++) begin
      tick(2'(i), o, e, h);
      if (e != 2'b00) on++;
    end
    end_f();
    chk(on == 0, req, on, 0);
  endtask

  task automatic write_mem(input int a, input logic [7:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
    model[a] = d;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [1:0] o, e, h;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(io_oe == 2'b00, "R1 reset oe", io_oe, 0);

    for (int i = 0; i < DEPTH; i++) write_mem(i, pat(i));

    // R2 R4: plain read across the whole array and past the wrap
    do_read(8'h03, 24'h000000, DEPTH + 4, "R2 R4 plain sweep");
    // R3: upper address bits ignored, wrap from top
    do_read(8'h03, 24'h1234FE, 4, "R3 masked address");
    // R5: fast read
    do_read(8'h0B, 24'h000080, 4, "R5 fast read");
    do_read(8'h0B, 24'hFFFFFD, 5, "R5 fast read wrap");
    // R6: dual read sweep and masked start
    do_read(8'hBB, 24'h000000, DEPTH + 4, "R6 R4 dual sweep");
    do_read(8'hBB, 24'hABCD7F, 3, "R6 dual masked");

    // R8: abort mid-byte
    start_f();
    send_byte(8'h03);
    send_addr(24'h000020, 1'b0);
    for (int i = 0; i < 4; i++) tick(2'b00, o, e, h);
    end_f();
    chk(io_oe == 2'b00, "R8 oe after abort", io_oe, 0);
    do_read(8'h03, 24'h000010, 2, "R8 fresh frame");

    // R1: outputs idle between frames
    chk(io_oe == 2'b00, "R1 idle oe", io_oe, 0);

    // R9: unknown opcodes
    quiet_frame(8'h5A, 48, "R9 unknown 5Ah");
    quiet_frame(8'h02, 48, "R9 unknown 02h");
    do_read(8'h03, 24'h000033, 2, "R9 recovery");

    // R10: busy rejects fast and dual
    busy = 1'b1;
    quiet_frame(8'h0B, 48, "R10 busy fast");
    quiet_frame(8'hBB, 40, "R10 busy dual");
    // R11: plain read still served while busy
    do_read(8'h03, 24'h0000F0, 3, "R11 busy plain");
    busy = 1'b0;
    do_read(8'h0B, 24'h000044, 2, "R10 fast after busy");

    // R12: overwrite through the array port
    write_mem(8'h40, 8'hC3);
    write_mem(8'h41, 8'h3C);
    do_read(8'h03, 24'h000040, 2, "R12 write port");
    do_read(8'hBB, 24'h000040, 2, "R12 write port dual");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule